// File: doc/BRIEF.md
# Process-Tagged Translation Cache with Large-Page Support

This block is a small fully associative cache of virtual-to-physical page translations. Every slot holds a virtual page number, a physical page number, a permission field, an address-space tag (process identifier) and a page-size code. A slot can map an ordinary 4 KB page, a 2 MB large page or a 1 GB large page. When a slot maps a large page, the compare ignores the virtual page bits below that size, and the physical address takes those bits from the request.

A request presents a virtual address and the running process identifier. One cycle later the block answers with hit or miss, the physical address and the permission bits. Because every slot carries its process identifier, slots belonging to other processes can stay resident across a context switch without ever hitting. On a miss the block only reports the miss. An outside agent (a hardware table walker or a kernel handler) then installs the translation through the fill port. A purge port removes one translation (matched by process identifier and address) or clears the whole cache in one cycle. Software uses it after a permission or mapping change.

A fill that overlaps a resident translation of the same process first evicts that translation, so at most one slot can ever hit. A new translation goes to the lowest-numbered free slot. When no slot is free, a round-robin pointer picks the victim.

Top module: `tlb_tagged`

## Requirements
- R1: After reset no slot is valid, `rsp_valid` and `rsp_hit` are low, and any lookup misses.
- R2: A lookup hits a 4 KB slot (size code 0) when the slot's virtual page number equals `lk_vaddr[47:12]` and its process identifier equals `lk_pid`. The response address is the slot's physical page number concatenated with `lk_vaddr[11:0]`, and `rsp_perm` is the slot's permission field.
- R3: A slot whose process identifier differs from `lk_pid` never hits, whatever its address.
- R4: Size code 1 (2 MB) ignores the low 9 virtual page bits in the compare, and size code 2 (1 GB) ignores the low 18. For such a slot, the same number of low physical page bits come from `lk_vaddr`, and the stored low bits are disregarded.
- R5: A lookup that matches no slot returns `rsp_valid` high with `rsp_hit` low and changes no slot.
- R6: A targeted purge (`purge_one`) invalidates only the slot whose process identifier equals `purge_pid` and whose page, under that slot's own size, contains `purge_vpn`. Slots of other processes or other pages stay valid.
- R7: A fill invalidates every valid slot of the same process whose page overlaps the new page, measured at the larger of the two sizes. At most one slot hits any lookup.
- R8: Every lookup produces exactly one response on the following cycle. A fill or purge in the same cycle as a lookup does not affect that lookup's answer; it takes effect for later lookups.
- R9: `purge_all` clears every slot in one cycle. If a fill is presented in that same cycle, the filled translation is kept.
- R10: A fill goes to the lowest-numbered invalid slot. When all slots are valid, it replaces the slot at a round-robin pointer. The pointer starts at 0 after reset and advances by one (wrapping) only on such a replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | 48 | Lookup virtual address |
| lk_pid | input | 8 | Current process identifier |
| rsp_valid | output | 1 | Lookup answer present (one cycle after request) |
| rsp_hit | output | 1 | Translation found |
| rsp_paddr | output | 40 | Translated physical address (valid on hit) |
| rsp_perm | output | 3 | Permission bits of hit slot |
| fill_valid | input | 1 | Install a translation |
| fill_pid | input | 8 | Process identifier of new translation |
| fill_vpn | input | 36 | Virtual page number (4 KB units) |
| fill_ppn | input | 28 | Physical page number (4 KB units) |
| fill_size | input | 2 | Page size code: 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| fill_perm | input | 3 | Permission bits of new translation |
| purge_one | input | 1 | Invalidate the matching translation |
| purge_all | input | 1 | Invalidate all translations |
| purge_pid | input | 8 | Process identifier for targeted purge |
| purge_vpn | input | 36 | Virtual page number for targeted purge |

## Verification
The bench builds the block with its default parameters: 16 slots, 48-bit virtual and 40-bit physical addresses, 8-bit process identifiers. Sixteen slots are few enough that the bench can fill every slot and then force the round-robin victim path twice in a row. The 40-bit physical width leaves room for 1 GB-aligned frames, so all three page sizes, the bit splicing they need and overlap eviction between a 2 MB page and a 4 KB page inside it are all within reach. Cycles with a lookup and a fill or purge together show that state changes land only after the answer.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    PG_4K = 2'd0,
    PG_2M = 2'd1,
    PG_1G = 2'd2
  } pg_size_e;

  localparam int unsigned LVL_BITS = 9;

  // number of low page-number bits that a page of this size leaves to the offset
  function automatic int unsigned low_vpn_bits(pg_size_e s);
    case (s)
      PG_2M:   return LVL_BITS;
      PG_1G:   return 2 * LVL_BITS;
      default: return 0;
    endcase
  endfunction

  // the larger of two sizes (used for overlap tests)
  function automatic pg_size_e larger(pg_size_e a, pg_size_e b);
    return (low_vpn_bits(a) >= low_vpn_bits(b)) ? a : b;
  endfunction

endpackage

// File: rtl/tlb_slot_cmp.sv
module tlb_slot_cmp
  import tlb_pkg::*;
#(
  parameter int PID_W = 8,
  parameter int VPN_W = 36
) (
  input  logic             e_valid,
  input  logic [PID_W-1:0] e_pid,
  input  logic [VPN_W-1:0] e_vpn,
  input  pg_size_e         e_size,
  input  logic [PID_W-1:0] lk_pid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [PID_W-1:0] pg_pid,
  input  logic [VPN_W-1:0] pg_vpn,
  input  logic [PID_W-1:0] fl_pid,
  input  logic [VPN_W-1:0] fl_vpn,
  input  pg_size_e         fl_size,
  output logic             lk_hit,
  output logic             pg_hit,
  output logic             fl_ovl
);

  function automatic logic [VPN_W-1:0] vpn_mask(pg_size_e s);
    return {VPN_W{1'b1}} << low_vpn_bits(s);
  endfunction

  function automatic logic same_page(logic [VPN_W-1:0] a, logic [VPN_W-1:0] b,
                                     pg_size_e s);
    return ((a ^ b) & vpn_mask(s)) == '0;
  endfunction

  assign lk_hit = e_valid && (e_pid == lk_pid) && same_page(e_vpn, lk_vpn, e_size);
  assign pg_hit = e_valid && (e_pid == pg_pid) && same_page(e_vpn, pg_vpn, e_size);
  assign fl_ovl = e_valid && (e_pid == fl_pid) &&
                  same_page(e_vpn, fl_vpn, larger(e_size, fl_size));

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid_mid,
  input  logic             fill_go,
  output logic [IDX_W-1:0] fill_idx,
  output logic             used_rr
);

  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] free_idx;
  logic             free_found;

  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_mid[i]) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  assign used_rr  = !free_found;
  assign fill_idx = free_found ? free_idx : rr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (fill_go && used_rr) begin
      rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/tlb_tagged.sv
module tlb_tagged
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter int PID_W   = 8,
  parameter int PERM_W  = 3,
  localparam int OFF_W  = 12,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PPN_W  = PA_W - OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [PID_W-1:0]  lk_pid,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [PERM_W-1:0] rsp_perm,
  input  logic              fill_valid,
  input  logic [PID_W-1:0]  fill_pid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [1:0]        fill_size,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              purge_one,
  input  logic              purge_all,
  input  logic [PID_W-1:0]  purge_pid,
  input  logic [VPN_W-1:0]  purge_vpn
);

  // physical address: stored frame above the page size, request bits below it
  function automatic logic [PA_W-1:0] build_pa(logic [PPN_W-1:0] ppn, pg_size_e s,
                                              logic [VA_W-1:0] va);
    logic [PPN_W-1:0] keep;
    logic [PPN_W-1:0] frame;
    keep  = {PPN_W{1'b1}} << low_vpn_bits(s);
    frame = (ppn & keep) | (va[OFF_W +: PPN_W] & ~keep);
    return {frame, va[OFF_W-1:0]};
  endfunction

  // slot state
  logic [ENTRIES-1:0] valid_q;
  logic [PID_W-1:0]   pid_q  [ENTRIES];
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  pg_size_e           size_q [ENTRIES];
  logic [PERM_W-1:0]  perm_q [ENTRIES];

  // named internal events (visible to the checker)
  logic [ENTRIES-1:0] lk_hit_vec;
  logic [ENTRIES-1:0] pg_hit_vec;
  logic [ENTRIES-1:0] fl_ovl_vec;
  logic [ENTRIES-1:0] valid_mid;
  logic [IDX_W-1:0]   fill_idx;
  logic               fill_used_rr;

  pg_size_e fill_size_e;
  assign fill_size_e = pg_size_e'(fill_size);

  logic [VPN_W-1:0] lk_vpn;
  assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    tlb_slot_cmp #(.PID_W(PID_W), .VPN_W(VPN_W)) u_cmp (
      .e_valid (valid_q[g]),
      .e_pid   (pid_q[g]),
      .e_vpn   (vpn_q[g]),
      .e_size  (size_q[g]),
      .lk_pid  (lk_pid),
      .lk_vpn  (lk_vpn),
      .pg_pid  (purge_pid),
      .pg_vpn  (purge_vpn),
      .fl_pid  (fill_pid),
      .fl_vpn  (fill_vpn),
      .fl_size (fill_size_e),
      .lk_hit  (lk_hit_vec[g]),
      .pg_hit  (pg_hit_vec[g]),
      .fl_ovl  (fl_ovl_vec[g])
    );
  end

  // valid bits after purges and overlap eviction, before the new fill lands
  always_comb begin
    valid_mid = valid_q;
    if (purge_all) begin
      valid_mid = '0;
    end else if (purge_one) begin
      valid_mid = valid_mid & ~pg_hit_vec;
    end
    if (fill_valid) begin
      valid_mid = valid_mid & ~fl_ovl_vec;
    end
  end

  tlb_victim #(.N(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_mid (valid_mid),
    .fill_go   (fill_valid),
    .fill_idx  (fill_idx),
    .used_rr   (fill_used_rr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        pid_q[i]  <= '0;
        vpn_q[i]  <= '0;
        ppn_q[i]  <= '0;
        size_q[i] <= PG_4K;
        perm_q[i] <= '0;
      end
    end else begin
      valid_q <= valid_mid;
      if (fill_valid) begin
        valid_q[fill_idx] <= 1'b1;
        pid_q[fill_idx]   <= fill_pid;
        vpn_q[fill_idx]   <= fill_vpn;
        ppn_q[fill_idx]   <= fill_ppn;
        size_q[fill_idx]  <= fill_size_e;
        perm_q[fill_idx]  <= fill_perm;
      end
    end
  end

  // select the (single) hitting slot by OR-reduction
  logic [PPN_W-1:0]  sel_ppn;
  logic [1:0]        sel_size;
  logic [PERM_W-1:0] sel_perm;

  always_comb begin
    sel_ppn  = '0;
    sel_size = '0;
    sel_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hit_vec[i]) begin
        sel_ppn  = sel_ppn  | ppn_q[i];
        sel_size = sel_size | size_q[i];
        sel_perm = sel_perm | perm_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && (lk_hit_vec != '0);
      if (lk_valid) begin
        rsp_paddr <= build_pa(sel_ppn, pg_size_e'(sel_size), lk_vaddr);
        rsp_perm  <= sel_perm;
      end
    end
  end

endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         lk_valid,
  input logic         rsp_valid,
  input logic         rsp_hit,
  input logic         fill_valid,
  input logic         purge_all,
  input logic [N-1:0] hit_vec,
  input logic [N-1:0] valid_vec
);

  a_r8_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  a_r8_no_spurious_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  a_r7_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r5_hit_only_with_answer: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  a_r9_global_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (purge_all && !fill_valid) |=> (valid_vec == '0));

  a_r9_fill_kept_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (purge_all && fill_valid) |=> ($countones(valid_vec) == 1));

  a_r10_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> (valid_vec != '0));

endmodule

bind tlb_tagged tlb_checker #(.N(ENTRIES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .fill_valid (fill_valid),
  .purge_all  (purge_all),
  .hit_vec    (lk_hit_vec),
  .valid_vec  (valid_q)
);

// File: tb/sim_tlb_tagged.sv
module sim_tlb_tagged;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid;
  logic [47:0] lk_vaddr;
  logic [7:0]  lk_pid;
  logic        rsp_valid, rsp_hit;
  logic [39:0] rsp_paddr;
  logic [2:0]  rsp_perm;
  logic        fill_valid;
  logic [7:0]  fill_pid;
  logic [35:0] fill_vpn;
  logic [27:0] fill_ppn;
  logic [1:0]  fill_size;
  logic [2:0]  fill_perm;
  logic        purge_one, purge_all;
  logic [7:0]  purge_pid;
  logic [35:0] purge_vpn;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic        q_hit  [$];
  logic [39:0] q_pa   [$];
  logic [2:0]  q_perm [$];
  string       q_tag  [$];

  always #(CLK_NS / 2) clk = ~clk;

  tlb_tagged u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm),
    .fill_valid(fill_valid), .fill_pid(fill_pid), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_size(fill_size), .fill_perm(fill_perm),
    .purge_one(purge_one), .purge_all(purge_all),
    .purge_pid(purge_pid), .purge_vpn(purge_vpn)
  );

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic idle();
    lk_valid = 0; lk_vaddr = '0; lk_pid = '0;
    fill_valid = 0; fill_pid = '0; fill_vpn = '0; fill_ppn = '0;
    fill_size = '0; fill_perm = '0;
    purge_one = 0; purge_all = 0; purge_pid = '0; purge_vpn = '0;
  endtask

  // advance one edge; strobes set before this are seen at that edge, then cleared
  task automatic go();
    @(posedge clk);
    #1 idle();
  endtask

  // driver side: arm a lookup and push the expected answer
  task automatic arm_lookup(logic [47:0] va, logic [7:0] pid, logic eh,
                            logic [39:0] epa, logic [2:0] eperm, string tag);
    lk_valid = 1; lk_vaddr = va; lk_pid = pid;
    q_hit.push_back(eh); q_pa.push_back(epa); q_perm.push_back(eperm);
    q_tag.push_back(tag);
  endtask

  task automatic arm_fill(logic [7:0] pid, logic [35:0] vpn, logic [27:0] ppn,
                          logic [1:0] sz, logic [2:0] perm);
    fill_valid = 1; fill_pid = pid; fill_vpn = vpn; fill_ppn = ppn;
    fill_size = sz; fill_perm = perm;
  endtask

  task automatic arm_purge(logic [7:0] pid, logic [35:0] vpn);
    purge_one = 1; purge_pid = pid; purge_vpn = vpn;
  endtask

  task automatic lookup(logic [47:0] va, logic [7:0] pid, logic eh,
                        logic [39:0] epa, logic [2:0] eperm, string tag);
    arm_lookup(va, pid, eh, epa, eperm, tag);
    go();
  endtask

  task automatic fill(logic [7:0] pid, logic [35:0] vpn, logic [27:0] ppn,
                      logic [1:0] sz, logic [2:0] perm);
    arm_fill(pid, vpn, ppn, sz, perm);
    go();
  endtask

  // monitor: pop and compare each answer
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_hit.size() == 0) begin
        check(0, "R8 unexpected answer", 64'(rsp_hit), 64'd0);
      end else begin
        logic        eh;
        logic [39:0] epa;
        logic [2:0]  ep;
        string       t;
        eh = q_hit.pop_front(); epa = q_pa.pop_front();
        ep = q_perm.pop_front(); t = q_tag.pop_front();
        check(rsp_hit == eh, {t, " hit"}, 64'(rsp_hit), 64'(eh));
        if (eh) begin
          check(rsp_paddr == epa, {t, " paddr"}, 64'(rsp_paddr), 64'(epa));
          check(rsp_perm == ep, {t, " perm"}, 64'(rsp_perm), 64'(ep));
        end
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    check(0, "watchdog expired", 64'd0, 64'd1);
    summary();
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    check(rsp_valid == 0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check(rsp_hit == 0, "R1 rsp_hit after reset", 64'(rsp_hit), 64'd0);
    lookup(48'h0000_1234_5123, 8'd5, 0, '0, '0, "R1 empty lookup");

    // R2: 4 KB page
    fill(8'd5, 36'h1_2345, 28'hABCDE, 2'd0, 3'b101);
    lookup(48'h0000_1234_5123, 8'd5, 1, 40'hAB_CDE1_23, 3'b101, "R2 4K hit");
    lookup(48'h0000_1234_6123, 8'd5, 0, '0, '0, "R5 neighbour page miss");
    // R3: other process
    lookup(48'h0000_1234_5123, 8'd6, 0, '0, '0, "R3 pid mismatch");

    // R4: 2 MB page, stored low frame bits disregarded
    fill(8'd5, 36'h4_0000, 28'h2AB, 2'd1, 3'b011);
    lookup(48'h0000_4012_3456, 8'd5, 1, 40'h00_0032_3456, 3'b011, "R4 2M hit");
    // R4: 1 GB page
    fill(8'd7, 36'h800_0000, 28'h40123, 2'd2, 3'b001);
    lookup(48'h0080_2345_6789, 8'd7, 1, 40'h00_6345_6789, 3'b001, "R4 1G hit");
    lookup(48'h0080_2345_6789, 8'd5, 0, '0, '0, "R3 1G pid mismatch");
    // R5: miss leaves entries intact
    lookup(48'h0000_1234_5000, 8'd5, 1, 40'hAB_CDE0_00, 3'b101, "R5 entry intact after miss");

    // R6: targeted purge
    arm_purge(8'd9, 36'h800_0000); go();
    lookup(48'h0080_0000_0000, 8'd7, 1, 40'h00_4000_0000, 3'b001, "R6 wrong pid purge ignored");
    arm_purge(8'd5, 36'h1_2345); go();
    lookup(48'h0000_1234_5123, 8'd5, 0, '0, '0, "R6 purged page misses");
    lookup(48'h0000_401F_FFFF, 8'd5, 1, 40'h00_003F_FFFF, 3'b011, "R6 other page kept");

    // R7: overlapping fill evicts 2 MB page
    fill(8'd5, 36'h4_0100, 28'h777, 2'd0, 3'b110);
    lookup(48'h0000_4000_0000, 8'd5, 0, '0, '0, "R7 overlapped 2M evicted");
    lookup(48'h0000_4010_0010, 8'd5, 1, 40'h00_0077_7010, 3'b110, "R7 new 4K hit");
    lookup(48'h0080_0000_0040, 8'd7, 1, 40'h00_4000_0040, 3'b001, "R7 other pid kept");

    // R8: lookup and purge same cycle
    arm_lookup(48'h0000_4010_0010, 8'd5, 1, 40'h00_0077_7010, 3'b110, "R8 lookup before purge");
    arm_purge(8'd5, 36'h4_0100);
    go();
    lookup(48'h0000_4010_0010, 8'd5, 0, '0, '0, "R8 purge applied after");
    // R8: lookup and fill same cycle
    arm_lookup(48'h0000_0555_5000, 8'd5, 0, '0, '0, "R8 lookup before fill");
    arm_fill(8'd5, 36'h5555, 28'h111, 2'd0, 3'b111);
    go();
    lookup(48'h0000_0555_5000, 8'd5, 1, 40'h00_0011_1000, 3'b111, "R8 fill applied after");

    // R9: global purge
    purge_all = 1; go();
    lookup(48'h0080_0000_0000, 8'd7, 0, '0, '0, "R9 1G cleared");
    lookup(48'h0000_0555_5000, 8'd5, 0, '0, '0, "R9 4K cleared");

    // R10: fill all 16 slots, then force round-robin replacement
    for (int i = 0; i < 16; i++) fill(8'd1, 36'h100 + 36'(i), 28'h200 + 28'(i), 2'd0, 3'b100);
    for (int i = 0; i < 16; i++)
      lookup(48'h100000 + 48'(i) * 48'h1000, 8'd1, 1, 40'h200000 + 40'(i) * 40'h1000, 3'b100,
             "R10 full table hit");
    fill(8'd1, 36'h1F0, 28'h3F0, 2'd0, 3'b100);
    lookup(48'h0000_0010_0000, 8'd1, 0, '0, '0, "R10 slot 0 replaced");
    lookup(48'h0000_0010_1000, 8'd1, 1, 40'h00_0020_1000, 3'b100, "R10 slot 1 kept");
    lookup(48'h0000_001F_0000, 8'd1, 1, 40'h00_003F_0000, 3'b100, "R10 new entry hit");
    fill(8'd1, 36'h1F1, 28'h3F1, 2'd0, 3'b100);
    lookup(48'h0000_0010_1000, 8'd1, 0, '0, '0, "R10 pointer advanced to slot 1");
    lookup(48'h0000_0010_2000, 8'd1, 1, 40'h00_0020_2000, 3'b100, "R10 slot 2 kept");

    // R9: global purge with simultaneous fill
    purge_all = 1;
    arm_fill(8'd2, 36'h999, 28'h888, 2'd0, 3'b010);
    go();
    lookup(48'h0000_0099_9000, 8'd2, 1, 40'h00_0088_8000, 3'b010, "R9 fill survives clear");
    lookup(48'h0000_0010_2000, 8'd1, 0, '0, '0, "R9 old entries cleared");

    repeat (3) go();
    check(q_hit.size() == 0, "R8 all answers delivered", 64'(q_hit.size()), 64'd0);
    summary();
  end

endmodule